// File: doc/BRIEF.md
# Toggle-Excited Four-State Mealy Sequencer

This block is a small synchronous sequencer with four states, one serial input and one output. Its state lives in two toggle-type storage bits. On every rising clock edge a bit inverts when its toggle enable is high and keeps its value when the enable is low. Fixed combinational equations of the serial input and the present state produce the two toggle enables. Each next state therefore comes from toggle excitation, not from a direct next-state assignment.

The output is high only in one state. The two-bit state is brought out so that a neighbouring block can decode where the sequencer stands. All four codes are legal states, so no recovery logic for illegal states is needed.

Top module: `toggle_seq`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 2'b00 at that edge. `yOut` is 0 in the following cycle.
- R2: From state 2'b00 (codes are written {bit1,bit0}), an edge with `xIn`=0 keeps 2'b00 and an edge with `xIn`=1 moves to 2'b10.
- R3: From state 2'b01, the next edge moves to 2'b11 for either value of `xIn`.
- R4: From state 2'b10, an edge with `xIn`=0 keeps 2'b10 and an edge with `xIn`=1 moves to 2'b01.
- R5: From state 2'b11, an edge with `xIn`=0 moves to 2'b01 and an edge with `xIn`=1 moves to 2'b00.
- R6: `yOut` is 1 exactly when the state is 2'b11. It depends on the state only and does not change when `xIn` changes between edges.
- R7: Bit 0 of the state inverts at an edge exactly when `xIn` and bit 1 were both 1 before that edge. Bit 1 inverts exactly when `xIn` or bit 0 was 1 before that edge. A bit that is not enabled keeps its value.
- R8: Reset takes priority over `xIn`. An edge with `rst`=1 and `xIn`=1 still gives 2'b00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| xIn | input | 1 | Serial input bit |
| yOut | output | 1 | Output, high in state 2'b11 |
| stateOut | output | 2 | Present state {bit1,bit0} |

## Verification
The state 2'b01 is the hardest case to reach from the ports. It can be entered only from 2'b10 with `xIn`=1 or from 2'b11 with `xIn`=0. The claim that `xIn` makes no difference there needs visits with both input values. A directed walk enters 2'b01 once by each route, once with `xIn` low and once with `xIn` high. A long random stream with occasional resets follows, and it is compared against a table model on every edge. Resets asserted with `xIn` high show that the input cannot override a reset.

// File: rtl/toggle_seq_pkg.sv
package toggle_seq_pkg;
  localparam int STATE_W = 2;
  localparam int HI_BIT  = 1;
  localparam int LO_BIT  = 0;

  typedef logic [STATE_W-1:0] seqState_t;

  localparam seqState_t ST_IDLE = 2'b00;
  localparam seqState_t ST_ARM  = 2'b01;
  localparam seqState_t ST_WAIT = 2'b10;
  localparam seqState_t ST_FIRE = 2'b11;

  typedef struct packed {
    logic [STATE_W-1:0] flip;
  } toggleStrobe_t;
endpackage

// File: rtl/toggle_seq_ctrl.sv
module toggle_seq_ctrl
  import toggle_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          xIn,
  input  seqState_t     curState,
  output toggleStrobe_t strobe
);
  always_comb begin
    strobe = '0;
    strobe.flip[LO_BIT] = xIn & curState[HI_BIT];
    strobe.flip[HI_BIT] = xIn | curState[LO_BIT];
  end

  AST_IDLE_STEP: assert property (@(posedge clk) disable iff (rst)
    curState == ST_IDLE |=> (rst || curState == ($past(xIn) ? ST_WAIT : ST_IDLE))); // R2
  AST_ARM_STEP: assert property (@(posedge clk) disable iff (rst)
    curState == ST_ARM |=> (rst || curState == ST_FIRE)); // R3
  AST_WAIT_STEP: assert property (@(posedge clk) disable iff (rst)
    curState == ST_WAIT |=> (rst || curState == ($past(xIn) ? ST_ARM : ST_WAIT))); // R4
  AST_FIRE_STEP: assert property (@(posedge clk) disable iff (rst)
    curState == ST_FIRE |=> (rst || curState == ($past(xIn) ? ST_IDLE : ST_ARM))); // R5
endmodule

// File: rtl/toggle_seq_dp.sv
module toggle_seq_dp
  import toggle_seq_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  toggleStrobe_t strobe,
  output seqState_t     stateQ
);
  for (genvar b = 0; b < STATE_W; b++) begin : g_tff
    always_ff @(posedge clk) begin
      if (rst)
        stateQ[b] <= 1'b0;
      else if (strobe.flip[b])
        stateQ[b] <= ~stateQ[b];
    end
  end

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> stateQ == ST_IDLE); // R1
  AST_BIT_TOGGLE_RULE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (stateQ ^ $past(stateQ)) == $past(strobe.flip)); // R7
endmodule

// File: rtl/toggle_seq.sv
module toggle_seq
  import toggle_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       xIn,
  output logic       yOut,
  output logic [1:0] stateOut
);
  seqState_t     curState;
  toggleStrobe_t strobe;

  toggle_seq_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .xIn      (xIn),
    .curState (curState),
    .strobe   (strobe)
  );

  toggle_seq_dp u_dp (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .stateQ (curState)
  );

  assign stateOut = curState;
  assign yOut     = curState[HI_BIT] & curState[LO_BIT];

  AST_FIRE_FROM_ARM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && yOut) |-> $past(stateOut) == ST_ARM); // R6
endmodule

// File: tb/toggle_seq_bench.sv
module toggle_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic xIn = 1'b0;
  logic yOut;
  logic [1:0] stateOut;

  int checks = 0;
  int fails = 0;
  int modelState = 0;
  bit finished = 1'b0;

  toggle_seq u_toggle_seq (
    .clk(clk), .rst(rst), .xIn(xIn), .yOut(yOut), .stateOut(stateOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int nextOf(int s, bit x);
    case (s)
      0: return x ? 2 : 0;
      1: return 3;
      2: return x ? 1 : 2;
      default: return x ? 0 : 1;
    endcase
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(bit xv, bit rv);
    int prev;
    int prevState;
    string tag;
    prev = modelState;
    prevState = int'(stateOut);
    xIn = xv;
    rst = rv;
    @(posedge clk);
    if (rv) modelState = 0;
    else modelState = nextOf(prev, xv);
    @(negedge clk);
    if (rv) tag = xv ? "R8" : "R1";
    else case (prev)
      0: tag = "R2";
      1: tag = "R3";
      2: tag = "R4";
      default: tag = "R5";
    endcase
    check(tag, int'(stateOut), modelState);
    check("R6", int'(yOut), (modelState == 3) ? 1 : 0);
    if (!rv) begin
      // R7: per-bit toggle rule, from the previous visible state and x
      check("R7", int'(stateOut[0] ^ prevState[0]), int'(xv & prevState[1]));
      check("R7", int'(stateOut[1] ^ prevState[1]), int'(xv | prevState[0]));
    end
    // R6: y must not follow x between edges
    xIn = ~xv;
    #1;
    check("R6", int'(yOut), (modelState == 3) ? 1 : 0);
    xIn = xv;
  endtask

  initial begin
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // R2: idle holds, then moves to wait
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    // R4: wait holds, then moves to arm
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    // R3: arm with x=0
    step(1'b0, 1'b0);
    // R5: fire with x=0 goes to arm, then R3 with x=1
    step(1'b0, 1'b0);
    step(1'b1, 1'b0);
    // R5: fire with x=1 goes to idle
    step(1'b1, 1'b0);
    // R8: reset from a non-idle state while x is high
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    for (int i = 0; i < 3000; i++) begin
      step(1'($urandom_range(0, 1)), ($urandom_range(0, 63) == 0));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule